// File: doc/BRIEF.md
# Odd-Address Word Splitter for a Byte-Banked 16-Bit Bus

This block sits between a processor core and the bus cycle sequencer of a 16-bit system. The data bus is built from two byte banks. The core issues one load or store at a time through a valid/ready handshake. A request is a byte or a word, goes to the memory space (20-bit addresses) or the isolated I/O space (16-bit addresses), and may use any address. The splitter turns each request into the bus cycles the banked bus needs. For every cycle it drives the address, the active-low high-bank enable and write data placed on the right byte lanes. Read data coming back is assembled into a right-justified result. A one-cycle done pulse ends the request.

A byte or an even-addressed word needs one bus cycle. A word at an odd address needs two. The first cycle moves the odd byte on the high lanes; that byte is the word's low byte. The second cycle moves the following even byte on the low lanes as the high byte. The block then swaps the two halves back into order.

The controller has four states:
- `ST_IDLE`: ready is high; an accepted request moves to `ST_FIRST`.
- `ST_FIRST`: the first bus cycle is held until `cyc_done`. It then moves to `ST_SECOND` if the request is a split word, else to `ST_FINISH`.
- `ST_SECOND`: the second bus cycle is held until `cyc_done`, then moves to `ST_FINISH`.
- `ST_FINISH`: raises `resp_done` for one cycle and returns to `ST_IDLE`.

Top module: `bus_split_unit`

## Requirements
- R1: After reset `req_ready` is 1, and `cyc_req` and `resp_done` are 0.
- R2: A byte at an even address takes one cycle with address bit 0 = 0 and `cyc_bhe_n` = 1. Write data travels on bits 7:0 with bits 15:8 zero, and read data comes from bits 7:0.
- R3: A byte at an odd address takes one cycle with address bit 0 = 1 and `cyc_bhe_n` = 0. The write byte (`req_wdata[7:0]`) is placed on bits 15:8 with bits 7:0 zero. Read data is taken from bits 15:8 and returned in `resp_rdata[7:0]`. For every byte read, `resp_rdata[15:8]` is 0.
- R4: A word at an even address takes one cycle with address bit 0 = 0 and `cyc_bhe_n` = 0, carrying all 16 bits unchanged in both directions.
- R5: A word at an odd address A takes two cycles. The first is at A with `cyc_bhe_n` = 0 and `req_wdata[7:0]` on bits 15:8 (bits 7:0 zero). The second is at A+1 with `cyc_bhe_n` = 1 and `req_wdata[15:8]` on bits 7:0 (bits 15:8 zero).
- R6: A word read at an odd address returns `{second cycle cyc_rdata[7:0], first cycle cyc_rdata[15:8]}`.
- R7: For a memory request the second-cycle address is A+1 modulo 2^20, so 0xFFFFF is followed by 0x00000.
- R8: An I/O request drives `cyc_mem` = 0 and forces address bits 19:16 to 0. Its second-cycle address is A+1 modulo 2^16, so 0xFFFF is followed by 0x0000. Memory requests drive `cyc_mem` = 1.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its `resp_done`, so no new request is taken while one is in progress.
- R10: `resp_done` is a single-cycle pulse in the cycle after the last `cyc_done`. `cyc_req` and the cycle fields stay unchanged from the start of a bus cycle until its `cyc_done`.
- R11: `cyc_write` follows the request direction, and a read cycle drives `cyc_wdata` as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Splitter can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_io | input | 1 | 1 = isolated I/O space, 0 = memory |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Store data, right-justified |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Load result, right-justified, valid with resp_done |
| cyc_req | output | 1 | Bus cycle requested; held until cyc_done |
| cyc_addr | output | 20 | Bus cycle address including bit 0 |
| cyc_bhe_n | output | 1 | Active-low high-bank enable |
| cyc_mem | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_write | output | 1 | 1 = write cycle |
| cyc_wdata | output | 16 | Lane-placed write data |
| cyc_done | input | 1 | Sequencer finished the current bus cycle |
| cyc_rdata | input | 16 | Read lanes, sampled with cyc_done |

## Verification
Suppose the controller takes the wrong branch out of `ST_FIRST`. The ports then show it within one bus cycle: a split word ends after a single cycle, or an aligned access issues a spurious second one. A wrong lane plan appears at once on `cyc_addr`, `cyc_bhe_n` and `cyc_wdata` in the first cycle of the faulty request. A wrong merge register first appears in `resp_rdata` at the done pulse, as bytes swapped or taken from the wrong lane. The directed tests cover each address parity, each size, both spaces and both wrap points, so each of these faults is seen within one request.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int BSU_AW    = 20;
    localparam int BSU_IO_AW = 16;
    localparam int BSU_DW    = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_FINISH = 2'd3
    } bsu_state_e;

endpackage

// File: rtl/bsu_addr_step.sv
module bsu_addr_step #(
    parameter int AW    = 20,
    parameter int IO_AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic          io,
    output logic [AW-1:0] next
);
    localparam int HI_W = AW - IO_AW;

    logic [IO_AW-1:0] io_next;

    always_comb begin
        io_next = base[IO_AW-1:0] + {{(IO_AW-1){1'b0}}, 1'b1};
        if (io)
            next = {{HI_W{1'b0}}, io_next};
        else
            next = base + {{(AW-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/bsu_plan.sv
module bsu_plan #(
    parameter int AW    = 20,
    parameter int IO_AW = 16,
    parameter int DW    = 16
) (
    input  logic          word,
    input  logic          io,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          split,
    output logic          odd,
    output logic [AW-1:0] addr0,
    output logic [AW-1:0] addr1,
    output logic          bhe0_n,
    output logic          bhe1_n,
    output logic [DW-1:0] wd0,
    output logic [DW-1:0] wd1
);
    localparam int BW   = DW / 2;
    localparam int HI_W = AW - IO_AW;

    logic [AW-1:0] addr_eff;
    logic [BW-1:0] lo_byte;
    logic [BW-1:0] hi_byte;

    always_comb begin
        addr_eff = io ? {{HI_W{1'b0}}, addr[IO_AW-1:0]} : addr;
        odd      = addr_eff[0];
        split    = word && odd;
        lo_byte  = wdata[BW-1:0];
        hi_byte  = wdata[DW-1:BW];
    end

    bsu_addr_step #(.AW(AW), .IO_AW(IO_AW)) u_step (
        .base (addr_eff),
        .io   (io),
        .next (addr1)
    );

    always_comb begin
        addr0  = addr_eff;
        bhe0_n = !word && !odd;
        bhe1_n = 1'b1;
        if (word && !odd)
            wd0 = wdata;
        else if (odd)
            wd0 = {lo_byte, {BW{1'b0}}};
        else
            wd0 = {{BW{1'b0}}, lo_byte};
        wd1 = {{BW{1'b0}}, hi_byte};
    end
endmodule

// File: rtl/bsu_read_merge.sv
module bsu_read_merge #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          cap_first,
    input  logic          cap_second,
    input  logic          word,
    input  logic          odd,
    input  logic [DW-1:0] lanes,
    output logic [DW-1:0] result
);
    localparam int BW = DW / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (clear) begin
            result <= '0;
        end else if (cap_first) begin
            if (word && odd)
                result[BW-1:0] <= lanes[DW-1:BW];
            else if (word)
                result <= lanes;
            else if (odd)
                result <= {{BW{1'b0}}, lanes[DW-1:BW]};
            else
                result <= {{BW{1'b0}}, lanes[BW-1:0]};
        end else if (cap_second) begin
            result[DW-1:BW] <= lanes[BW-1:0];
        end
    end
endmodule

// File: rtl/bus_split_unit.sv
module bus_split_unit
    import bsu_pkg::*;
#(
    parameter int AW    = BSU_AW,
    parameter int IO_AW = BSU_IO_AW,
    parameter int DW    = BSU_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_word,
    input  logic          req_io,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          resp_done,
    output logic [DW-1:0] resp_rdata,
    output logic          cyc_req,
    output logic [AW-1:0] cyc_addr,
    output logic          cyc_bhe_n,
    output logic          cyc_mem,
    output logic          cyc_write,
    output logic [DW-1:0] cyc_wdata,
    input  logic          cyc_done,
    input  logic [DW-1:0] cyc_rdata
);
    bsu_state_e state, state_nx;

    logic          q_write, q_word, q_io;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_wdata;
    logic          accept;

    logic          p_split, p_odd, p_bhe0_n, p_bhe1_n;
    logic [AW-1:0] p_addr0, p_addr1;
    logic [DW-1:0] p_wd0, p_wd1;

    assign accept = req_valid && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_word  <= 1'b0;
            q_io    <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
        end else if (accept) begin
            q_write <= req_write;
            q_word  <= req_word;
            q_io    <= req_io;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
        end
    end

    bsu_plan #(.AW(AW), .IO_AW(IO_AW), .DW(DW)) u_plan (
        .word   (q_word),
        .io     (q_io),
        .addr   (q_addr),
        .wdata  (q_wdata),
        .split  (p_split),
        .odd    (p_odd),
        .addr0  (p_addr0),
        .addr1  (p_addr1),
        .bhe0_n (p_bhe0_n),
        .bhe1_n (p_bhe1_n),
        .wd0    (p_wd0),
        .wd1    (p_wd1)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_FIRST;
            ST_FIRST:  if (cyc_done)  state_nx = p_split ? ST_SECOND : ST_FINISH;
            ST_SECOND: if (cyc_done)  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    bsu_read_merge #(.DW(DW)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .cap_first  ((state == ST_FIRST) && cyc_done),
        .cap_second ((state == ST_SECOND) && cyc_done),
        .word       (q_word),
        .odd        (p_odd),
        .lanes      (cyc_rdata),
        .result     (resp_rdata)
    );

    always_comb begin
        req_ready = 1'b0;
        resp_done = 1'b0;
        cyc_req   = 1'b0;
        cyc_addr  = '0;
        cyc_bhe_n = 1'b1;
        cyc_mem   = 1'b0;
        cyc_write = 1'b0;
        cyc_wdata = '0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_FIRST: begin
                cyc_req   = 1'b1;
                cyc_addr  = p_addr0;
                cyc_bhe_n = p_bhe0_n;
                cyc_mem   = !q_io;
                cyc_write = q_write;
                cyc_wdata = q_write ? p_wd0 : '0;
            end
            ST_SECOND: begin
                cyc_req   = 1'b1;
                cyc_addr  = p_addr1;
                cyc_bhe_n = p_bhe1_n;
                cyc_mem   = !q_io;
                cyc_write = q_write;
                cyc_wdata = q_write ? p_wd1 : '0;
            end
            ST_FINISH: resp_done = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !cyc_done) |=> (cyc_req && $stable(cyc_addr) && $stable(cyc_bhe_n) && $stable(cyc_wdata)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> (!resp_done && req_ready));

    // R8
    io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !cyc_mem) |-> (cyc_addr[AW-1:IO_AW] == '0));

    // R2
    bank_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req |-> !(cyc_addr[0] && cyc_bhe_n));

    // R5
    second_low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && $past(cyc_done) && $past(cyc_req)) |-> (!cyc_addr[0] && cyc_bhe_n));

    // R11
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !cyc_write) |-> (cyc_wdata == '0));
endmodule

// File: tb/bus_split_unit_test.sv
module bus_split_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_io = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, resp_done, cyc_req, cyc_bhe_n, cyc_mem, cyc_write;
    logic [15:0] resp_rdata, cyc_wdata;
    logic [19:0] cyc_addr;
    logic        cyc_done = 1'b0;
    logic [15:0] cyc_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;

    int          ncyc;
    logic [19:0] c_addr [0:2];
    logic        c_bhe  [0:2];
    logic        c_mem  [0:2];
    logic        c_wr   [0:2];
    logic [15:0] c_wd   [0:2];
    logic [15:0] rd_data [0:1];
    logic [15:0] got_rdata;
    logic        got_done, busy_ready, unstable, after_pulse_low, after_ready;

    always #10 clk = ~clk;

    bus_split_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_word(req_word), .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_done(resp_done), .resp_rdata(resp_rdata),
        .cyc_req(cyc_req), .cyc_addr(cyc_addr), .cyc_bhe_n(cyc_bhe_n), .cyc_mem(cyc_mem),
        .cyc_write(cyc_write), .cyc_wdata(cyc_wdata), .cyc_done(cyc_done), .cyc_rdata(cyc_rdata)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic wr, input logic wd, input logic io,
                           input logic [19:0] a, input logic [15:0] d);
        int guard;
        ncyc = 0; got_done = 0; busy_ready = 0; unstable = 0; got_rdata = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_io = io;
        req_addr = a; req_wdata = d;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0; req_addr = '0; req_wdata = '0;
        guard = 0;
        while (!got_done && guard < 200) begin
            guard++;
            if (req_ready) busy_ready = 1'b1;
            if (resp_done) begin
                got_done = 1'b1;
                got_rdata = resp_rdata;
            end else if (cyc_req) begin
                if (ncyc < 3) begin
                    c_addr[ncyc] = cyc_addr; c_bhe[ncyc] = cyc_bhe_n; c_mem[ncyc] = cyc_mem;
                    c_wr[ncyc] = cyc_write; c_wd[ncyc] = cyc_wdata;
                end
                @(negedge clk);
                if (ncyc < 3 && (!cyc_req || cyc_addr !== c_addr[ncyc] ||
                    cyc_bhe_n !== c_bhe[ncyc] || cyc_wdata !== c_wd[ncyc])) unstable = 1'b1;
                cyc_rdata = rd_data[(ncyc < 2) ? ncyc : 0];
                cyc_done = 1'b1;
                @(negedge clk);
                cyc_done = 1'b0; cyc_rdata = '0;
                ncyc++;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        after_pulse_low = !resp_done;
        after_ready = req_ready;
    endtask

    task automatic check_cycle(input int i, input string tag, input logic [19:0] a,
                               input logic bhe, input logic mem, input logic wr, input logic [15:0] wd);
        chk(c_addr[i] === a, {tag, " addr"}, 32'(c_addr[i]), 32'(a));
        chk(c_bhe[i] === bhe, {tag, " bhe_n"}, 32'(c_bhe[i]), 32'(bhe));
        chk(c_mem[i] === mem, {tag, " mem"}, 32'(c_mem[i]), 32'(mem));
        chk(c_wr[i] === wr, {tag, " write R11"}, 32'(c_wr[i]), 32'(wr));
        chk(c_wd[i] === wd, {tag, " wdata"}, 32'(c_wd[i]), 32'(wd));
    endtask

    task automatic check_tail(input string tag, input int exp_cyc);
        chk(ncyc == exp_cyc, {tag, " cycle count"}, 32'(ncyc), 32'(exp_cyc));
        chk(got_done, {tag, " R10 done seen"}, 32'(got_done), 32'd1);
        chk(!busy_ready, {tag, " R9 ready while busy"}, 32'(busy_ready), 32'd0);
        chk(!unstable, {tag, " R10 fields held"}, 32'(unstable), 32'd0);
        chk(after_pulse_low && after_ready, {tag, " R10 single pulse"},
            32'({after_pulse_low, after_ready}), 32'h3);
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(cyc_req === 1'b0, "R1 cyc_req", 32'(cyc_req), 32'd0);
        chk(resp_done === 1'b0, "R1 done", 32'(resp_done), 32'd0);
    endtask

    task automatic t_even_byte;
        run_req(1, 0, 0, 20'h12344, 16'hAB5A);
        check_tail("R2 wr", 1);
        check_cycle(0, "R2 wr", 20'h12344, 1, 1, 1, 16'h005A);
        rd_data[0] = 16'hC37E;
        run_req(0, 0, 0, 20'h00010, 16'hFFFF);
        check_tail("R2 rd", 1);
        check_cycle(0, "R2 rd R11", 20'h00010, 1, 1, 0, 16'h0000);
        chk(got_rdata === 16'h007E, "R2 rdata", 32'(got_rdata), 32'h007E);
    endtask

    task automatic t_odd_byte;
        run_req(1, 0, 0, 20'h00021, 16'h1234);
        check_tail("R3 wr", 1);
        check_cycle(0, "R3 wr", 20'h00021, 0, 1, 1, 16'h3400);
        rd_data[0] = 16'h9A55;
        run_req(0, 0, 0, 20'h00021, 16'h0);
        check_tail("R3 rd", 1);
        chk(got_rdata === 16'h009A, "R3 rdata", 32'(got_rdata), 32'h009A);
    endtask

    task automatic t_even_word;
        run_req(1, 1, 0, 20'h40000, 16'hBEEF);
        check_tail("R4 wr", 1);
        check_cycle(0, "R4 wr", 20'h40000, 0, 1, 1, 16'hBEEF);
        rd_data[0] = 16'h5AC3;
        run_req(0, 1, 0, 20'h40002, 16'h0);
        check_tail("R4 rd", 1);
        chk(got_rdata === 16'h5AC3, "R4 rdata", 32'(got_rdata), 32'h5AC3);
    endtask

    task automatic t_odd_word;
        run_req(1, 1, 0, 20'h00101, 16'hA1B2);
        check_tail("R5 wr", 2);
        check_cycle(0, "R5 first", 20'h00101, 0, 1, 1, 16'hB200);
        check_cycle(1, "R5 second", 20'h00102, 1, 1, 1, 16'h00A1);
        rd_data[0] = 16'h4433; rd_data[1] = 16'h2211;
        run_req(0, 1, 0, 20'h00101, 16'h0);
        check_tail("R6 rd", 2);
        chk(got_rdata === 16'h1144, "R6 rdata", 32'(got_rdata), 32'h1144);
    endtask

    task automatic t_mem_wrap;
        rd_data[0] = 16'h7700; rd_data[1] = 16'h0066;
        run_req(0, 1, 0, 20'hFFFFF, 16'h0);
        check_tail("R7", 2);
        check_cycle(0, "R7 first", 20'hFFFFF, 0, 1, 0, 16'h0000);
        check_cycle(1, "R7 second", 20'h00000, 1, 1, 0, 16'h0000);
        chk(got_rdata === 16'h6677, "R7 rdata", 32'(got_rdata), 32'h6677);
    endtask

    task automatic t_io;
        rd_data[0] = 16'hE100;
        run_req(0, 0, 1, 20'hF0073, 16'h0);
        check_tail("R8 io byte", 1);
        check_cycle(0, "R8 io byte", 20'h00073, 0, 0, 0, 16'h0000);
        chk(got_rdata === 16'h00E1, "R8 io rdata", 32'(got_rdata), 32'h00E1);
        run_req(1, 1, 1, 20'h0FFFF, 16'hC0DE);
        check_tail("R8 io wrap", 2);
        check_cycle(0, "R8 io first", 20'h0FFFF, 0, 0, 1, 16'hDE00);
        check_cycle(1, "R8 io second", 20'h00000, 1, 0, 1, 16'h00C0);
        rd_data[0] = 16'h1357;
        run_req(0, 1, 1, 20'h3A000, 16'h0);
        check_tail("R8 io word", 1);
        check_cycle(0, "R8 io word", 20'h0A000, 0, 0, 0, 16'h0000);
        chk(got_rdata === 16'h1357, "R8 io word rdata", 32'(got_rdata), 32'h1357);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rd_data[0] = '0; rd_data[1] = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_even_byte;
        t_odd_byte;
        t_even_word;
        t_odd_word;
        t_mem_wrap;
        t_io;
        repeat (2) @(negedge clk);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule